// File: doc/BRIEF.md
# Register-Mapped SPI Master with Transfer Chaining

This block is an SPI bus master that a host drives through three 32-bit registers: a data register, a transfer-setup register and a configuration register. Each transfer has two phases. It first shifts out a programmed number of bits, then shifts in a programmed number of bits. Each phase has its own clock divider, so a slow readback can follow a fast command without reprogramming.

Writing the data register starts a transfer. If a transfer is already running, the word waits as a single pending entry and starts on the cycle the current transfer finishes. Chip select stays asserted across the join, so chained transfers run back to back. The configuration flags set clock polarity, clock phase, chip-select polarity, bit order, half-duplex operation on a shared data line, and an offline mode that parks every pin at its inactive level.

Top module: `spim_top`

## Requirements
- R1: A bus access is a read when address bit 2 is set. Address bits 1:0 select the register: 0 is data, 1 is transfer setup, 2 is configuration, and 3 reads as zero. Read data appears on `bus_rdata` with `bus_rvalid` high one cycle after the access. After reset, configuration reads 0x0404_0000 and transfer setup reads 0.
- R2: Configuration bits 1 (active) and 2 (pending) are live status bits. Host writes to these two positions have no effect on what is read back.
- R3: The write phase shifts `wlen` bits (transfer bits 23:16). Each bit lasts `wdiv` = configuration bits 23:16 plus 2 clocks. The read phase then shifts `rlen` bits (transfer bits 31:24). Each read bit lasts configuration bits 31:24 plus 2 clocks. Chip select stays asserted for exactly wlen*wdiv + rlen*rdiv clocks.
- R4: With configuration bit 6 clear, transmission starts at data bit 31 and moves downward. Received bits are right-aligned, and the first bit received ends up as the most significant of the `rlen` bits.
- R5: With configuration bit 6 set, transmission starts at data bit 0 and moves upward. The i-th received bit is stored in data bit i.
- R6: When no transfer runs, SCLK rests at configuration bit 4. With configuration bit 5 clear, the input is sampled on the first clock edge of each bit. With bit 5 set, the data output changes on the first edge and the input is sampled on the second.
- R7: Lines whose bit is set in the transfer mask (bits 15:0) assert during a transfer, and all other lines stay inactive. Configuration bit 3 set makes chip select active-high.
- R8: A data write during a transfer sets the pending bit. The queued word starts on the cycle the current transfer ends, chip select is not released between the two, and the pending bit clears at that point.
- R9: While configuration bit 0 (offline) is set, every chip select is inactive, SCLK rests at idle, the active bit reads 0, and a data write starts no transfer, then or later.
- R10: With configuration bit 7 set, `spi_mosi_oe` is low for exactly the read phase. Received bits are taken from `spi_mosi_in`, and `spi_miso` is ignored.
- R11: Whenever no chip select is active, SCLK equals the clock-polarity flag and `spi_mosi_oe` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_stb | input | 1 | Bus access strobe, one cycle per access |
| bus_addr | input | 3 | Bit 2 selects read; bits 1:0 select the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data |
| bus_rvalid | output | 1 | High one cycle after a read access |
| spi_sclk | output | 1 | Serial clock |
| spi_mosi | output | 1 | Serial data out |
| spi_mosi_oe | output | 1 | Output enable for the data-out line |
| spi_mosi_in | input | 1 | Data-out line as seen at the pad (half-duplex receive) |
| spi_miso | input | 1 | Serial data in |
| spi_cs | output | NCS | Chip-select lines |

## Verification
The checker watches, on every cycle, the idle pin levels, offline parking, the rule that pending implies active, the read-response timing, and the rule that the output enable drops only in half-duplex mode. Bit order, per-phase divider timing, continuity of chip select across a chained pair, and the right alignment of received data depend on whole transfers. Only the bench scenarios can show these: a behavioural slave logs each sampled data-out bit and drives a known pattern back to the block.

// File: rtl/spim_pkg.sv
package spim_pkg;
  localparam logic [1:0] SEL_DATA = 2'd0;
  localparam logic [1:0] SEL_XFER = 2'd1;
  localparam logic [1:0] SEL_CFG  = 2'd2;
  localparam logic [7:0] DIV_RST  = 8'd4;

  typedef struct packed {
    logic half;
    logic lsb;
    logic cpha;
    logic cpol;
    logic cspol;
    logic offline;
  } mode_t;
endpackage

// File: rtl/spim_regs.sv
module spim_regs
  import spim_pkg::*;
#(
  parameter int NCS = 16
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           bus_stb,
  input  logic [2:0]     bus_addr,
  input  logic [31:0]    bus_wdata,
  input  logic [31:0]    rx_word,
  input  logic           active,
  input  logic           pending,
  output mode_t          mode,
  output logic [7:0]     wdiv_f,
  output logic [7:0]     rdiv_f,
  output logic [NCS-1:0] cs_mask,
  output logic [7:0]     wlen,
  output logic [7:0]     rlen,
  output logic           data_wr,
  output logic [31:0]    data_word,
  output logic [31:0]    bus_rdata,
  output logic           bus_rvalid
);
  logic        is_rd, is_wr;
  logic [15:0] mask16;
  logic [31:0] cfg_view, rd_mux;

  assign is_rd     = bus_stb & bus_addr[2];
  assign is_wr     = bus_stb & ~bus_addr[2];
  assign data_wr   = is_wr && (bus_addr[1:0] == SEL_DATA);
  assign data_word = bus_wdata;

  always_comb begin
    mask16 = '0;
    mask16[NCS-1:0] = cs_mask;
    cfg_view = {rdiv_f, wdiv_f, 8'h00, mode.half, mode.lsb, mode.cpha,
                mode.cpol, mode.cspol, pending, active, mode.offline};
    case (bus_addr[1:0])
      SEL_DATA: rd_mux = rx_word;
      SEL_XFER: rd_mux = {rlen, wlen, mask16};
      SEL_CFG:  rd_mux = cfg_view;
      default:  rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      mode       <= '0;
      wdiv_f     <= DIV_RST;
      rdiv_f     <= DIV_RST;
      cs_mask    <= '0;
      wlen       <= '0;
      rlen       <= '0;
      bus_rdata  <= '0;
      bus_rvalid <= 1'b0;
    end else begin
      bus_rvalid <= is_rd;
      if (is_rd) bus_rdata <= rd_mux;
      if (is_wr && bus_addr[1:0] == SEL_CFG) begin
        mode.offline <= bus_wdata[0];
        mode.cspol   <= bus_wdata[3];
        mode.cpol    <= bus_wdata[4];
        mode.cpha    <= bus_wdata[5];
        mode.lsb     <= bus_wdata[6];
        mode.half    <= bus_wdata[7];
        wdiv_f       <= bus_wdata[23:16];
        rdiv_f       <= bus_wdata[31:24];
      end
      if (is_wr && bus_addr[1:0] == SEL_XFER) begin
        cs_mask <= bus_wdata[NCS-1:0];
        wlen    <= bus_wdata[23:16];
        rlen    <= bus_wdata[31:24];
      end
    end
  end
endmodule

// File: rtl/spim_engine.sv
module spim_engine
  import spim_pkg::*;
#(
  parameter int NCS = 16
) (
  input  logic           clk,
  input  logic           rst,
  input  mode_t          mode,
  input  logic [7:0]     wdiv_f,
  input  logic [7:0]     rdiv_f,
  input  logic [NCS-1:0] cs_mask,
  input  logic [7:0]     wlen,
  input  logic [7:0]     rlen,
  input  logic           data_wr,
  input  logic [31:0]    data_word,
  input  logic           rx_bit,
  output logic           busy,
  output logic           pend,
  output logic [31:0]    rx_word,
  output logic [NCS-1:0] cur_mask,
  output logic           sclk_lvl,
  output logic           tx_bit,
  output logic           rd_phase
);
  localparam int CW = 9;

  logic [31:0]   pend_word, tx_word, rx_acc, rx_nxt, go_word;
  logic [CW-1:0] cnt, slot, div_cur, half, total, rd_idx;
  logic [7:0]    lat_w, lat_r, lat_wdiv, lat_rdiv;
  logic          in_wr, last_cnt, last_slot, fin, cap, free, go;

  always_comb begin
    in_wr     = slot < {1'b0, lat_w};
    div_cur   = in_wr ? ({1'b0, lat_wdiv} + 9'd2) : ({1'b0, lat_rdiv} + 9'd2);
    half      = div_cur >> 1;
    last_cnt  = (cnt == div_cur - 9'd1);
    total     = {1'b0, lat_w} + {1'b0, lat_r};
    last_slot = (slot == total - 9'd1);
    fin       = busy && last_cnt && last_slot;
    cap       = busy && !in_wr && (cnt == half);
    rd_idx    = slot - {1'b0, lat_w};
    rx_nxt    = rx_acc;
    if (cap) begin
      if (mode.lsb) begin
        if (rd_idx < 9'd32) rx_nxt[rd_idx[4:0]] = rx_bit;
      end else begin
        rx_nxt = {rx_acc[30:0], rx_bit};
      end
    end
    free    = !busy || fin;
    go      = free && (pend || data_wr);
    go_word = pend ? pend_word : data_word;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      busy      <= 1'b0;
      pend      <= 1'b0;
      pend_word <= '0;
      tx_word   <= '0;
      rx_acc    <= '0;
      rx_word   <= '0;
      cnt       <= '0;
      slot      <= '0;
      lat_w     <= '0;
      lat_r     <= '0;
      lat_wdiv  <= DIV_RST;
      lat_rdiv  <= DIV_RST;
      cur_mask  <= '0;
    end else if (mode.offline) begin
      busy <= 1'b0;
      pend <= 1'b0;
    end else begin
      rx_acc <= rx_nxt;
      if (busy) begin
        if (last_cnt) begin
          cnt  <= '0;
          slot <= slot + 9'd1;
        end else begin
          cnt <= cnt + 9'd1;
        end
      end
      if (fin) begin
        rx_word <= rx_nxt;
        busy    <= 1'b0;
      end
      if (data_wr) pend_word <= data_word;
      if (free) pend <= pend && data_wr;
      else if (data_wr) pend <= 1'b1;
      if (go) begin
        busy     <= 1'b1;
        cnt      <= '0;
        slot     <= '0;
        tx_word  <= go_word;
        rx_acc   <= '0;
        lat_w    <= wlen;
        lat_r    <= (wlen == 8'd0 && rlen == 8'd0) ? 8'd1 : rlen;
        lat_wdiv <= wdiv_f;
        lat_rdiv <= rdiv_f;
        cur_mask <= cs_mask;
      end
    end
  end

  always_comb begin
    tx_bit = 1'b0;
    if (in_wr && slot < 9'd32)
      tx_bit = mode.lsb ? tx_word[slot[4:0]] : tx_word[5'd31 - slot[4:0]];
  end

  assign sclk_lvl = mode.cpol ^ (mode.cpha ? (cnt < half) : (cnt >= half));
  assign rd_phase = busy && !in_wr;
endmodule

// File: rtl/spim_pins.sv
module spim_pins
  import spim_pkg::*;
#(
  parameter int NCS = 16
) (
  input  logic           clk,
  input  logic           rst,
  input  mode_t          mode,
  input  logic           busy,
  input  logic [NCS-1:0] cur_mask,
  input  logic           sclk_lvl,
  input  logic           tx_bit,
  input  logic           rd_phase,
  output logic [NCS-1:0] cs,
  output logic           sclk,
  output logic           mosi,
  output logic           mosi_oe
);
  logic run;
  assign run = busy && !mode.offline;

  for (genvar g = 0; g < NCS; g++) begin : g_cs
    always_ff @(posedge clk) begin
      if (rst) cs[g] <= 1'b1;
      else     cs[g] <= (run && cur_mask[g]) ? mode.cspol : ~mode.cspol;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sclk    <= 1'b0;
      mosi    <= 1'b0;
      mosi_oe <= 1'b1;
    end else begin
      sclk    <= run ? sclk_lvl : mode.cpol;
      mosi    <= run ? tx_bit : 1'b0;
      mosi_oe <= !(run && mode.half && rd_phase);
    end
  end
endmodule

// File: rtl/spim_top.sv
module spim_top
  import spim_pkg::*;
#(
  parameter int NCS = 16
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           bus_stb,
  input  logic [2:0]     bus_addr,
  input  logic [31:0]    bus_wdata,
  output logic [31:0]    bus_rdata,
  output logic           bus_rvalid,
  output logic           spi_sclk,
  output logic           spi_mosi,
  output logic           spi_mosi_oe,
  input  logic           spi_mosi_in,
  input  logic           spi_miso,
  output logic [NCS-1:0] spi_cs
);
  mode_t          mode_q;
  logic [7:0]     wdiv_f, rdiv_f, wlen, rlen;
  logic [NCS-1:0] cs_mask, cur_mask;
  logic [31:0]    data_word, rx_word;
  logic           data_wr, eng_busy, eng_pend, sclk_lvl, tx_bit, rd_phase, rx_bit;

  assign rx_bit = mode_q.half ? spi_mosi_in : spi_miso;

  spim_regs #(.NCS(NCS)) u_regs (
    .clk(clk), .rst(rst), .bus_stb(bus_stb), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .rx_word(rx_word), .active(eng_busy),
    .pending(eng_pend), .mode(mode_q), .wdiv_f(wdiv_f), .rdiv_f(rdiv_f),
    .cs_mask(cs_mask), .wlen(wlen), .rlen(rlen), .data_wr(data_wr),
    .data_word(data_word), .bus_rdata(bus_rdata), .bus_rvalid(bus_rvalid)
  );

  spim_engine #(.NCS(NCS)) u_eng (
    .clk(clk), .rst(rst), .mode(mode_q), .wdiv_f(wdiv_f), .rdiv_f(rdiv_f),
    .cs_mask(cs_mask), .wlen(wlen), .rlen(rlen), .data_wr(data_wr),
    .data_word(data_word), .rx_bit(rx_bit), .busy(eng_busy), .pend(eng_pend),
    .rx_word(rx_word), .cur_mask(cur_mask), .sclk_lvl(sclk_lvl),
    .tx_bit(tx_bit), .rd_phase(rd_phase)
  );

  spim_pins #(.NCS(NCS)) u_pins (
    .clk(clk), .rst(rst), .mode(mode_q), .busy(eng_busy), .cur_mask(cur_mask),
    .sclk_lvl(sclk_lvl), .tx_bit(tx_bit), .rd_phase(rd_phase),
    .cs(spi_cs), .sclk(spi_sclk), .mosi(spi_mosi), .mosi_oe(spi_mosi_oe)
  );
endmodule

// File: rtl/spim_checker.sv
module spim_checker
  import spim_pkg::*;
#(
  parameter int NCS = 16
) (
  input logic           clk,
  input logic           rst,
  input logic           bus_stb,
  input logic [2:0]     bus_addr,
  input logic           bus_rvalid,
  input logic [NCS-1:0] spi_cs,
  input logic           spi_sclk,
  input logic           spi_mosi_oe,
  input mode_t          mode,
  input logic           active,
  input logic           pending
);
  // R1: a read access is answered exactly one cycle later
  p_rvalid_follows_r1: assert property (@(posedge clk) disable iff (rst)
    (bus_stb && bus_addr[2]) |=> bus_rvalid);
  p_rvalid_quiet_r1: assert property (@(posedge clk) disable iff (rst)
    !(bus_stb && bus_addr[2]) |=> !bus_rvalid);

  // R8: a queued word exists only behind a running transfer
  p_pending_needs_active_r8: assert property (@(posedge clk) disable iff (rst)
    pending |-> active);

  // R9: offline stops the engine and parks the chip selects
  p_offline_halts_r9: assert property (@(posedge clk) disable iff (rst)
    mode.offline |=> !active);
  p_offline_parks_r9: assert property (@(posedge clk) disable iff (rst)
    mode.offline |=> (spi_cs == {NCS{~$past(mode.cspol)}}));

  // R10: the data-out driver is released only in half-duplex mode
  p_oe_half_only_r10: assert property (@(posedge clk) disable iff (rst)
    !spi_mosi_oe |-> $past(mode.half));

  // R11: idle pin levels
  p_idle_pins_r11: assert property (@(posedge clk) disable iff (rst)
    !active |=> (spi_cs == {NCS{~$past(mode.cspol)}} &&
                 spi_sclk == $past(mode.cpol) && spi_mosi_oe));
endmodule

bind spim_top spim_checker #(.NCS(NCS)) u_chk (
  .clk(clk), .rst(rst), .bus_stb(bus_stb), .bus_addr(bus_addr),
  .bus_rvalid(bus_rvalid), .spi_cs(spi_cs), .spi_sclk(spi_sclk),
  .spi_mosi_oe(spi_mosi_oe), .mode(mode_q), .active(eng_busy),
  .pending(eng_pend)
);

// File: tb/spim_top_tb_top.sv
module spim_top_tb_top;
  localparam int NCS = 4;
  localparam logic [31:0] PAT = 32'hC3A5_96F0;

  logic           clk = 1'b0;
  logic           rst = 1'b1;
  logic           bus_stb = 1'b0;
  logic [2:0]     bus_addr = '0;
  logic [31:0]    bus_wdata = '0;
  logic [31:0]    bus_rdata;
  logic           bus_rvalid;
  logic           spi_sclk, spi_mosi, spi_mosi_oe, spi_mosi_in, spi_miso;
  logic [NCS-1:0] spi_cs;

  always #5 clk = ~clk;

  spim_top #(.NCS(NCS)) dut_i (
    .clk(clk), .rst(rst), .bus_stb(bus_stb), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .bus_rvalid(bus_rvalid),
    .spi_sclk(spi_sclk), .spi_mosi(spi_mosi), .spi_mosi_oe(spi_mosi_oe),
    .spi_mosi_in(spi_mosi_in), .spi_miso(spi_miso), .spi_cs(spi_cs)
  );

  // Behavioural slave and expectation state
  logic exp_cpol = 1'b0, exp_cpha = 1'b0, exp_cspol = 1'b0, exp_offline = 1'b0;
  logic hd_mode = 1'b0, mon_en = 1'b0, slave_bit = 1'b0;
  logic act_prev = 1'b0, sclk_prev = 1'b0;
  logic mlog [0:255];
  int idx = 0, cs_cyc = 0, cs_win = 0, oe_low = 0, idle_err = 0;
  logic [NCS-1:0] cs_seen = '0;
  int n_chk = 0, n_fail = 0;
  bit done = 0;

  assign spi_mosi_in = spi_mosi_oe ? spi_mosi : slave_bit;
  assign spi_miso    = hd_mode ? ~slave_bit : slave_bit;

  function automatic logic pat_bit(int k);
    return PAT[31 - (k % 32)];
  endfunction

  function automatic logic [31:0] exp_rx(int s, int r, bit lsb);
    logic [31:0] v = '0;
    for (int j = 0; j < r; j++) begin
      if (lsb) v[j] = pat_bit(s + j);
      else     v = {v[30:0], pat_bit(s + j)};
    end
    return v;
  endfunction

  function automatic logic [31:0] got_tx(int s, int w, bit lsb);
    logic [31:0] v = '0;
    for (int i = 0; i < w; i++) begin
      if (lsb) v[i] = mlog[s + i];
      else     v = {v[30:0], mlog[s + i]};
    end
    return v;
  endfunction

  function automatic logic cs_active(logic [NCS-1:0] c);
    return exp_cspol ? (c != '0) : (c != '1);
  endfunction

  always @(negedge clk) begin
    if (!rst && mon_en) begin
      logic act;
      act = cs_active(spi_cs);
      if (act && !act_prev) begin
        cs_win++;
        idx = 0;
      end else if (act && spi_sclk != sclk_prev &&
                   spi_sclk == (exp_cpha ? exp_cpol : !exp_cpol)) begin
        mlog[idx] = spi_mosi_in;
        idx++;
      end
      slave_bit = pat_bit(idx);
      if (act) begin
        cs_cyc++;
        cs_seen = cs_seen | (exp_cspol ? spi_cs : ~spi_cs);
      end
      if (!spi_mosi_oe) oe_low++;
      if (!act && (spi_sclk !== exp_cpol || spi_mosi_oe !== 1'b1)) idle_err++;
      if (exp_offline && act) idle_err++;
    end
    act_prev  = cs_active(spi_cs);
    sclk_prev = spi_sclk;
  end

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic bus_write(logic [1:0] a, logic [31:0] d);
    @(negedge clk);
    bus_stb = 1'b1; bus_addr = {1'b0, a}; bus_wdata = d;
    @(negedge clk);
    bus_stb = 1'b0;
  endtask

  task automatic bus_read(logic [1:0] a, output logic [31:0] d, output logic v);
    @(negedge clk);
    bus_stb = 1'b1; bus_addr = {1'b1, a};
    @(negedge clk);
    bus_stb = 1'b0;
    d = bus_rdata;
    v = bus_rvalid;
  endtask

  task automatic set_cfg(logic [31:0] c);
    mon_en = 1'b0;
    bus_write(2'd2, c);
    exp_offline = c[0]; exp_cspol = c[3]; exp_cpol = c[4]; exp_cpha = c[5];
    repeat (2) @(negedge clk);
    mon_en = 1'b1;
  endtask

  task automatic clear_mon();
    cs_cyc = 0; cs_win = 0; oe_low = 0; cs_seen = '0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    logic [31:0] rd, t6_rx;
    logic rv;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    mon_en = 1'b1;
    @(negedge clk);
    // R11 reset pin levels
    check("R11 reset cs", {28'd0, spi_cs}, 32'h0000_000F);
    check("R11 reset sclk/oe", {30'd0, spi_sclk, spi_mosi_oe}, 32'd1);
    // R1 reset register contents and read timing
    bus_read(2'd2, rd, rv);
    check("R1 cfg reset", rd, 32'h0404_0000);
    check("R1 rvalid", {31'd0, rv}, 32'd1);
    bus_read(2'd1, rd, rv);
    check("R1 xfer reset", rd, 32'h0);
    // R2 status bits are not writable
    set_cfg(32'h0404_0006);
    bus_read(2'd2, rd, rv);
    check("R2 status ignores writes", rd, 32'h0404_0000);

    // Mode 0, MSB first, 8 out / 8 in, divider 6
    bus_write(2'd1, {8'd8, 8'd8, 16'h0001});
    bus_read(2'd1, rd, rv);
    check("R1 xfer readback", rd, 32'h0808_0001);
    clear_mon();
    bus_write(2'd0, 32'hA500_0000);
    repeat (120) @(negedge clk);
    check("R3 cs duration 8x6+8x6", cs_cyc, 96);
    check("R7 only line 0", {28'd0, cs_seen}, 32'h1);
    check("R4 msb tx", got_tx(0, 8, 0), 32'hA5);
    bus_read(2'd0, rd, rv);
    check("R4 msb rx right-aligned", rd, exp_rx(8, 8, 0));

    // CPOL1 CPHA1, LSB first, write div 4, read div 10
    set_cfg(32'h0802_0070);
    bus_write(2'd1, {8'd5, 8'd12, 16'h0004});
    clear_mon();
    bus_write(2'd0, 32'h0000_0ABC);
    repeat (130) @(negedge clk);
    check("R3 cs duration 12x4+5x10", cs_cyc, 98);
    check("R5 lsb tx", got_tx(0, 12, 1), 32'hABC);
    bus_read(2'd0, rd, rv);
    check("R5 lsb rx", rd, exp_rx(12, 5, 1));
    check("R7 only line 2", {28'd0, cs_seen}, 32'h4);
    check("R6 sclk idle high", {31'd0, spi_sclk}, 32'd1);

    // Chaining, CPOL1 CPHA0
    set_cfg(32'h0404_0010);
    bus_write(2'd1, {8'd4, 8'd8, 16'h0002});
    clear_mon();
    bus_write(2'd0, 32'h3C00_0000);
    bus_write(2'd0, 32'hF000_0000);
    bus_read(2'd2, rd, rv);
    check("R8 pending+active while queued", {30'd0, rd[2:1]}, 32'd3);
    repeat (170) @(negedge clk);
    check("R8 single cs window", cs_win, 1);
    check("R8 back-to-back duration", cs_cyc, 144);
    check("R6 first tx mode cpha0", got_tx(0, 8, 0), 32'h3C);
    check("R8 second tx", got_tx(12, 8, 0), 32'hF0);
    bus_read(2'd0, rd, rv);
    check("R8 second rx", rd, exp_rx(20, 4, 0));
    bus_read(2'd2, rd, rv);
    check("R8 status cleared", {30'd0, rd[2:1]}, 32'd0);

    // Half duplex, active-high chip select
    set_cfg(32'h0404_0088);
    check("R7 active-high idle", {28'd0, spi_cs}, 32'h0);
    bus_write(2'd1, {8'd8, 8'd4, 16'h0008});
    clear_mon();
    hd_mode = 1'b1;
    bus_write(2'd0, 32'h9000_0000);
    repeat (120) @(negedge clk);
    check("R10 oe low for read phase", oe_low, 48);
    check("R10 tx", got_tx(0, 4, 0), 32'h9);
    bus_read(2'd0, rd, rv);
    t6_rx = rd;
    check("R10 rx from shared line", rd, exp_rx(4, 8, 0));
    check("R7 active-high line 3", {28'd0, cs_seen}, 32'h8);

    // Offline
    hd_mode = 1'b0;
    set_cfg(32'h0404_0009);
    clear_mon();
    bus_write(2'd0, 32'hFFFF_FFFF);
    repeat (40) @(negedge clk);
    check("R9 no transfer offline", cs_win, 0);
    bus_read(2'd2, rd, rv);
    check("R9 active stays 0", {31'd0, rd[1]}, 32'd0);
    bus_read(2'd0, rd, rv);
    check("R9 data unchanged", rd, t6_rx);
    set_cfg(32'h0404_0008);
    repeat (20) @(negedge clk);
    check("R9 dropped word never starts", cs_win, 0);

    check("R11 idle levels every cycle", idle_err, 0);
    finish_run();
  end
endmodule